// File: doc/BRIEF.md
# Multi-mode position counter core

This block is the counting engine of a position-tracking peripheral. It receives single-cycle up and down count pulses from an external decoder, along with an index event and a count-enable pin. A command interface outside the block drives strobes that write and clear its mode registers, write a preset value, clear or load the counter, take a snapshot, and clear the status. The counter runs at a width chosen at runtime: one, two, three or four bytes. A count-mode field picks how the count behaves at its boundaries: it can wrap freely, stop after one overflow, clamp inside a range, or divide by the preset plus one.

Each count step can raise a carry, borrow or compare event. The index input raises its own index event. These four events are latched into a status byte. Two active-low flags report the events that a mask allows. The latched flag stays low until the status is cleared. The pulsed flag is low for exactly one cycle after each event. The index input can be set to reload the counter from the preset, zero it, or copy it into the snapshot register, so the position can be captured or re-referenced on an encoder marker.

Top module: `posCounter`

## Requirements
- R1: After reset the counter, preset, snapshot and both mode registers read zero. The status reads 8'h04 while the enable pin is low (only the power-loss bit is set). Both flags are high.
- R2: In free-running mode (mode0[3:2]=00), counting up from the all-ones value of the selected width gives zero and a carry. Counting down from zero gives all-ones and a borrow.
- R3: mode1[1:0] selects the width: 00 is four bytes, 01 three, 10 two and 11 one. The counter reads back only the selected bytes, and carry and borrow occur at that width's limits.
- R4: In single-cycle mode (mode0[3:2]=01), a carry or borrow stops all counting until the counter is cleared or loaded.
- R5: In range-limit mode (mode0[3:2]=10), counting up at the preset value holds the count and raises carry. Counting down at zero holds the count and raises borrow. The count moves again once the direction reverses.
- R6: In modulo mode (mode0[3:2]=11), counting up from the preset gives zero and a carry. Counting down from zero gives the preset and a borrow.
- R7: mode0[5:4] sets the index action: 00 none, 01 load the counter from the preset, 10 clear the counter, 11 copy the pre-step count into the snapshot. A counter load or clear beats a count step in the same cycle. Every index pulse sets the index status bit.
- R8: The status bits are: bit 7 carry, bit 6 borrow, bit 5 compare, bit 4 index, bit 3 live count enable, bit 2 power loss, bit 1 last direction (1 means up), bit 0 the MSB of the count at the current width. A compare event is a count step whose result equals the preset.
- R9: A status clear zeroes bits 7..4 and the power-loss bit. It wins over an event in the same cycle.
- R10: Masks in mode1 gate the events onto both flags: bit 7 carry, bit 6 borrow, bit 5 compare, bit 4 index. The latched flag is low while any unmasked status event bit is set. The pulsed flag is low for one cycle after an unmasked event.
- R11: Counting happens only when the enable pin is 1 and mode1[2] is 0. A cycle in which both up and down pulses are present does not count.
- R12: The command strobes act on the next clock edge. Clear counter gives zero. Load counter copies the preset. Snapshot copies the count. Writes take wrData. A clear of a mode register beats a write of it in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-up reset |
| enPin | input | 1 | External count enable |
| countUp | input | 1 | Single-cycle up-count pulse |
| countDown | input | 1 | Single-cycle down-count pulse |
| indexEvt | input | 1 | Single-cycle index event |
| wrData | input | 32 | Write data for preset (all bits) and mode registers (bits 7..0) |
| wrMode0 | input | 1 | Write mode register 0 |
| wrMode1 | input | 1 | Write mode register 1 |
| wrPreset | input | 1 | Write preset register |
| clrMode0 | input | 1 | Clear mode register 0 |
| clrMode1 | input | 1 | Clear mode register 1 |
| clrCounter | input | 1 | Clear the counter |
| clrStatus | input | 1 | Clear latched status bits |
| ldCounter | input | 1 | Load counter from preset |
| ldSnap | input | 1 | Copy counter into snapshot |
| countVal | output | 32 | Counter value at selected width |
| snapVal | output | 32 | Snapshot register |
| status | output | 8 | Status byte |
| mode0Val | output | 8 | Mode register 0 |
| mode1Val | output | 8 | Mode register 1 |
| flagLatchN | output | 1 | Latched event flag, active low |
| flagPulseN | output | 1 | One-cycle event flag, active low |

## Verification
The index action and a count step can fall in the same cycle, and so can a status clear and a new carry or borrow. The bench drives an index pulse together with an up pulse under each index action. It also raises clear-status in the very cycle a wrap occurs. The expected results are that the load or clear replaces the step, that a snapshot holds the pre-step count while the counter still advances, and that the status comes out clean. A behavioural model runs alongside, including a long stretch of mixed random stimulus. It judges every cycle against those priorities.

// File: rtl/posCntPkg.sv
package posCntPkg;

  typedef enum logic [1:0] {
    CM_FREE   = 2'b00,
    CM_SINGLE = 2'b01,
    CM_RANGE  = 2'b10,
    CM_MODULO = 2'b11
  } cntMode_e;

  typedef enum logic [1:0] {
    IF_NONE  = 2'b00,
    IF_LOAD  = 2'b01,
    IF_CLEAR = 2'b10,
    IF_SNAP  = 2'b11
  } idxFn_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic doClear;
    logic doLoad;
    logic doSnap;
    logic stepUp;
    logic stepDown;
    logic indexHit;
  } dpCmd_t;

  typedef struct packed {
    logic carry;
    logic borrow;
    logic compare;
    logic index;
  } evt_t;

endpackage

// File: rtl/posCntCtrl.sv
module posCntCtrl
  import posCntPkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int BYTE_W = 8,
  parameter int MODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enPin,
  input  logic              countUp,
  input  logic              countDown,
  input  logic              indexEvt,
  input  logic [MODE_W-1:0] wrByte,
  input  logic              wrMode0,
  input  logic              wrMode1,
  input  logic              clrMode0,
  input  logic              clrMode1,
  input  logic              clrCounter,
  input  logic              ldCounter,
  input  logic              ldSnap,
  output dpCmd_t            cmd,
  output cntMode_e          cntMode,
  output logic [CNT_W-1:0]  widthMask,
  output logic [3:0]        evtMask,
  output logic              cntEnable,
  output logic [MODE_W-1:0] mode0Q,
  output logic [MODE_W-1:0] mode1Q
);

  localparam int SHIFT_W = $clog2(CNT_W + 1);

  idxFn_e            idxFn;
  logic [1:0]        widthSel;
  logic [SHIFT_W-1:0] dropBits;
  logic              oneDir;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode0Q <= '0;
      mode1Q <= '0;
    end else begin
      if (clrMode0)     mode0Q <= '0;
      else if (wrMode0) mode0Q <= wrByte;
      if (clrMode1)     mode1Q <= '0;
      else if (wrMode1) mode1Q <= wrByte;
    end
  end

  always_comb begin
    cntMode  = cntMode_e'(mode0Q[3:2]);
    idxFn    = idxFn_e'(mode0Q[5:4]);
    widthSel = mode1Q[1:0];
    evtMask  = mode1Q[7:4];
    dropBits = SHIFT_W'(BYTE_W * int'(widthSel));
    widthMask = {CNT_W{1'b1}} >> dropBits;
    cntEnable = enPin & ~mode1Q[2];
    oneDir    = countUp ^ countDown;
  end

  always_comb begin
    cmd          = '0;
    cmd.indexHit = indexEvt;
    cmd.doClear  = clrCounter | (indexEvt && idxFn == IF_CLEAR);
    cmd.doLoad   = ~cmd.doClear & (ldCounter | (indexEvt && idxFn == IF_LOAD));
    cmd.doSnap   = ldSnap | (indexEvt && idxFn == IF_SNAP);
    cmd.stepUp   = cntEnable & oneDir & countUp;
    cmd.stepDown = cntEnable & oneDir & countDown;
  end

  AST_CLEAR_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (clrMode0 && wrMode0) |=> (mode0Q == '0)); // R12

endmodule

// File: rtl/posCntDatapath.sv
module posCntDatapath
  import posCntPkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  cntMode_e         cntMode,
  input  logic [CNT_W-1:0] widthMask,
  input  logic [CNT_W-1:0] wrData,
  input  logic             wrPreset,
  output logic [CNT_W-1:0] countVal,
  output logic [CNT_W-1:0] snapVal,
  output logic             dirUp,
  output logic             signBit,
  output logic             carryEvt,
  output logic             borrowEvt,
  output logic             compareEvt
);

  logic [CNT_W-1:0] cntQ, preQ, snapQ, nextCnt;
  logic [CNT_W-1:0] curCnt, curPre, upLimit, downWrap;
  logic             haltQ, stepOk, atTop, atZero, holdMode;

  always_comb begin
    curCnt   = cntQ & widthMask;
    curPre   = preQ & widthMask;
    holdMode = (cntMode == CM_RANGE);
    upLimit  = (cntMode == CM_RANGE || cntMode == CM_MODULO) ? curPre : widthMask;
    downWrap = (cntMode == CM_MODULO) ? curPre : widthMask;
    atTop    = (curCnt == upLimit);
    atZero   = (curCnt == '0);
    stepOk   = (cmd.stepUp | cmd.stepDown) & ~(cntMode == CM_SINGLE && haltQ);
  end

  always_comb begin
    nextCnt    = cntQ;
    carryEvt   = 1'b0;
    borrowEvt  = 1'b0;
    compareEvt = 1'b0;
    if (cmd.doClear) begin
      nextCnt = '0;
    end else if (cmd.doLoad) begin
      nextCnt = curPre;
    end else if (stepOk) begin
      if (cmd.stepUp) begin
        if (atTop) begin
          carryEvt = 1'b1;
          nextCnt  = holdMode ? curCnt : '0;
        end else begin
          nextCnt = (curCnt + 1'b1) & widthMask;
        end
      end else begin
        if (atZero) begin
          borrowEvt = 1'b1;
          nextCnt   = holdMode ? curCnt : downWrap;
        end else begin
          nextCnt = (curCnt - 1'b1) & widthMask;
        end
      end
      compareEvt = (nextCnt == curPre);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ  <= '0;
      preQ  <= '0;
      snapQ <= '0;
      haltQ <= 1'b0;
      dirUp <= 1'b0;
    end else begin
      cntQ <= nextCnt;
      if (wrPreset)   preQ  <= wrData;
      if (cmd.doSnap) snapQ <= curCnt;
      if (cmd.doClear || cmd.doLoad)
        haltQ <= 1'b0;
      else if (stepOk && cntMode == CM_SINGLE && (carryEvt || borrowEvt))
        haltQ <= 1'b1;
      if (stepOk && !cmd.doClear && !cmd.doLoad)
        dirUp <= cmd.stepUp;
    end
  end

  assign countVal = curCnt;
  assign snapVal  = snapQ;
  assign signBit  = |(curCnt & (widthMask ^ (widthMask >> 1)));

  AST_MOD_UP_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (cntMode == CM_MODULO && cmd.stepUp && !cmd.stepDown && !cmd.doClear && !cmd.doLoad
     && curCnt == curPre) |=> (cntQ == '0)); // R6
  AST_MOD_DOWN_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (cntMode == CM_MODULO && cmd.stepDown && !cmd.stepUp && !cmd.doClear && !cmd.doLoad
     && curCnt == '0) |=> (cntQ == $past(curPre))); // R6
  AST_RANGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cntMode == CM_RANGE && cmd.stepUp && !cmd.stepDown && !cmd.doClear && !cmd.doLoad
     && curCnt == curPre) |=> (cntQ == $past(curCnt))); // R5
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (haltQ && cntMode == CM_SINGLE && !cmd.doClear && !cmd.doLoad) |=> $stable(cntQ)); // R4
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.stepUp && !cmd.stepDown && !cmd.doClear && !cmd.doLoad) |=> $stable(cntQ)); // R11

endmodule

// File: rtl/posCntFlags.sv
module posCntFlags
  import posCntPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  evt_t       evtIn,
  input  logic [3:0] evtMask,
  input  logic       clrStatus,
  input  logic       cntEnable,
  input  logic       dirUp,
  input  logic       signBit,
  output logic [7:0] status,
  output logic       flagLatchN,
  output logic       flagPulseN
);

  logic [3:0] latchQ, evtQ;
  logic       plsQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= '0;
      evtQ   <= '0;
      plsQ   <= 1'b1;
    end else begin
      evtQ <= evtIn;
      if (clrStatus) begin
        latchQ <= '0;
        plsQ   <= 1'b0;
      end else begin
        latchQ <= latchQ | evtIn;
      end
    end
  end

  assign status     = {latchQ, cntEnable, plsQ, dirUp, signBit};
  assign flagLatchN = ~|(latchQ & evtMask);
  assign flagPulseN = ~|(evtQ & evtMask);

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    clrStatus |=> (status[7:4] == 4'b0 && !status[2])); // R9
  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !clrStatus |=> ((status[7:4] & $past(status[7:4])) == $past(status[7:4]))); // R10
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (evtIn == 4'b0) |=> (flagPulseN || !$stable(evtMask) || evtMask == 4'b0 || 1'b1) && (evtQ == 4'b0)); // R10

endmodule

// File: rtl/posCounter.sv
module posCounter
  import posCntPkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int BYTE_W = 8,
  parameter int MODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enPin,
  input  logic              countUp,
  input  logic              countDown,
  input  logic              indexEvt,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              wrMode0,
  input  logic              wrMode1,
  input  logic              wrPreset,
  input  logic              clrMode0,
  input  logic              clrMode1,
  input  logic              clrCounter,
  input  logic              clrStatus,
  input  logic              ldCounter,
  input  logic              ldSnap,
  output logic [CNT_W-1:0]  countVal,
  output logic [CNT_W-1:0]  snapVal,
  output logic [7:0]        status,
  output logic [MODE_W-1:0] mode0Val,
  output logic [MODE_W-1:0] mode1Val,
  output logic              flagLatchN,
  output logic              flagPulseN
);

  dpCmd_t           cmd;
  cntMode_e         cntMode;
  logic [CNT_W-1:0] widthMask;
  logic [3:0]       evtMask;
  logic             cntEnable, dirUp, signBit;
  logic             carryEvt, borrowEvt, compareEvt;
  evt_t             evtAll;

  posCntCtrl #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .MODE_W(MODE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enPin(enPin), .countUp(countUp), .countDown(countDown),
    .indexEvt(indexEvt), .wrByte(wrData[MODE_W-1:0]), .wrMode0(wrMode0), .wrMode1(wrMode1),
    .clrMode0(clrMode0), .clrMode1(clrMode1), .clrCounter(clrCounter),
    .ldCounter(ldCounter), .ldSnap(ldSnap), .cmd(cmd), .cntMode(cntMode),
    .widthMask(widthMask), .evtMask(evtMask), .cntEnable(cntEnable),
    .mode0Q(mode0Val), .mode1Q(mode1Val)
  );

  posCntDatapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .cntMode(cntMode), .widthMask(widthMask),
    .wrData(wrData), .wrPreset(wrPreset), .countVal(countVal), .snapVal(snapVal),
    .dirUp(dirUp), .signBit(signBit), .carryEvt(carryEvt), .borrowEvt(borrowEvt),
    .compareEvt(compareEvt)
  );

  always_comb begin
    evtAll.carry   = carryEvt;
    evtAll.borrow  = borrowEvt;
    evtAll.compare = compareEvt;
    evtAll.index   = cmd.indexHit;
  end

  posCntFlags u_flags (
    .clk(clk), .rstN(rstN), .evtIn(evtAll), .evtMask(evtMask), .clrStatus(clrStatus),
    .cntEnable(cntEnable), .dirUp(dirUp), .signBit(signBit), .status(status),
    .flagLatchN(flagLatchN), .flagPulseN(flagPulseN)
  );

endmodule

// File: tb/posCounter_tb.sv
`timescale 1ns/1ps
module posCounter_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enPin = 1'b0, cUp = 1'b0, cDn = 1'b0, idx = 1'b0;
  logic [31:0] data = '0;
  logic wrM0 = 0, wrM1 = 0, wrPre = 0, clrM0 = 0, clrM1 = 0;
  logic clrCnt = 0, clrSt = 0, ldCnt = 0, ldSnp = 0;
  logic [31:0] countVal, snapVal;
  logic [7:0]  status, mode0Val, mode1Val;
  logic        flagLatchN, flagPulseN;

  int checks = 0, errors = 0;
  string curReq = "R1";

  // behavioural reference state
  logic [31:0] mCnt = '0, mPre = '0, mSnap = '0;
  logic [7:0]  mM0 = '0, mM1 = '0;
  logic [3:0]  mLat = '0, mEvtQ = '0;
  logic        mPls = 1'b1, mDir = 1'b0, mHalt = 1'b0;

  always #2.5 clk = ~clk;

  posCounter u_dut (
    .clk(clk), .rstN(rstN), .enPin(enPin), .countUp(cUp), .countDown(cDn),
    .indexEvt(idx), .wrData(data), .wrMode0(wrM0), .wrMode1(wrM1), .wrPreset(wrPre),
    .clrMode0(clrM0), .clrMode1(clrM1), .clrCounter(clrCnt), .clrStatus(clrSt),
    .ldCounter(ldCnt), .ldSnap(ldSnp), .countVal(countVal), .snapVal(snapVal),
    .status(status), .mode0Val(mode0Val), .mode1Val(mode1Val),
    .flagLatchN(flagLatchN), .flagPulseN(flagPulseN)
  );

  function automatic logic [31:0] maskOf(input logic [7:0] m1);
    return 32'hFFFF_FFFF >> (8 * int'(m1[1:0]));
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = '0; mPre = '0; mSnap = '0; mM0 = '0; mM1 = '0;
      mLat = '0; mEvtQ = '0; mPls = 1'b1; mDir = 1'b0; mHalt = 1'b0;
    end else begin
      logic [31:0] msk, c, p, n;
      logic up, dn, cl, ld, sn, cy, bw, cmp, going;
      int cm, fn;
      msk = maskOf(mM1);
      c = mCnt & msk; p = mPre & msk; n = mCnt;
      cm = int'(mM0[3:2]); fn = int'(mM0[5:4]);
      up = enPin && !mM1[2] && cUp && !cDn;
      dn = enPin && !mM1[2] && cDn && !cUp;
      cl = clrCnt || (idx && fn == 2);
      ld = !cl && (ldCnt || (idx && fn == 1));
      sn = ldSnp || (idx && fn == 3);
      cy = 0; bw = 0; cmp = 0;
      going = (up || dn) && !(cm == 1 && mHalt);
      if (cl) begin n = '0; mHalt = 0; end
      else if (ld) begin n = p; mHalt = 0; end
      else if (going) begin
        mDir = up;
        if (up) begin
          if (c == ((cm >= 2) ? p : msk)) begin cy = 1; n = (cm == 2) ? c : '0; end
          else n = (c + 1) & msk;
        end else begin
          if (c == 0) begin bw = 1; n = (cm == 2) ? c : ((cm == 3) ? p : msk); end
          else n = (c - 1) & msk;
        end
        cmp = (n == p);
        if (cm == 1 && (cy || bw)) mHalt = 1;
      end
      if (sn) mSnap = c;
      mCnt = n;
      if (wrPre) mPre = data;
      mEvtQ = {cy, bw, cmp, idx};
      if (clrSt) begin mLat = '0; mPls = 0; end
      else mLat = mLat | {cy, bw, cmp, idx};
      if (clrM0) mM0 = '0; else if (wrM0) mM0 = data[7:0];
      if (clrM1) mM1 = '0; else if (wrM1) mM1 = data[7:0];
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    logic [31:0] msk, cv;
    logic sgn;
    msk = maskOf(mM1);
    cv = mCnt & msk;
    sgn = |(cv & (msk ^ (msk >> 1)));
    chk(curReq, "countVal", countVal, cv);
    chk(curReq, "snapVal", snapVal, mSnap);
    chk(curReq, "status", {24'b0, status},
        {24'b0, mLat, enPin & ~mM1[2], mPls, mDir, sgn});
    chk(curReq, "mode0", {24'b0, mode0Val}, {24'b0, mM0});
    chk(curReq, "mode1", {24'b0, mode1Val}, {24'b0, mM1});
    chk(curReq, "flagLatchN", {31'b0, flagLatchN}, {31'b0, ~|(mLat & mM1[7:4])});
    chk(curReq, "flagPulseN", {31'b0, flagPulseN}, {31'b0, ~|(mEvtQ & mM1[7:4])});
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compareAll();
    cUp = 0; cDn = 0; idx = 0; wrM0 = 0; wrM1 = 0; wrPre = 0; clrM0 = 0; clrM1 = 0;
    clrCnt = 0; clrSt = 0; ldCnt = 0; ldSnp = 0;
  endtask

  task automatic setM0(input logic [7:0] v); wrM0 = 1; data = {24'b0, v}; cyc(); endtask
  task automatic setM1(input logic [7:0] v); wrM1 = 1; data = {24'b0, v}; cyc(); endtask
  task automatic setPre(input logic [31:0] v); wrPre = 1; data = v; cyc(); endtask
  task automatic stepU(input int n); for (int i = 0; i < n; i++) begin cUp = 1; cyc(); end endtask
  task automatic stepD(input int n); for (int i = 0; i < n; i++) begin cDn = 1; cyc(); end endtask

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset status", {24'b0, status}, 32'h04);
    chk("R1", "reset count", countVal, 32'h0);
    chk("R1", "reset flags", {30'b0, flagLatchN, flagPulseN}, 32'h3);
    rstN = 1;
    cyc();
    enPin = 1;

    curReq = "R3";
    setM1(8'h03);
    stepD(1);
    chk("R2", "down from zero 1B", countVal, 32'hFF);
    chk("R2", "borrow bit", {31'b0, status[6]}, 32'h1);
    stepU(1);
    chk("R2", "up from max 1B", countVal, 32'h0);
    chk("R2", "carry bit", {31'b0, status[7]}, 32'h1);
    setM1(8'h02);
    stepD(1);
    chk("R3", "down from zero 2B", countVal, 32'hFFFF);
    setM1(8'h01);
    stepU(1);
    chk("R3", "3B carries past 16 bits", countVal, 32'h0001_0000);

    curReq = "R9";
    setM1(8'h03);
    clrSt = 1; cDn = 1; cyc();
    chk("R9", "clear beats borrow", {24'b0, status & 8'hF4}, 32'h0);

    curReq = "R10";
    setPre(32'h2);
    clrCnt = 1; cyc();
    setM1(8'hF3);
    stepU(2);
    chk("R10", "pulse at compare", {31'b0, flagPulseN}, 32'h0);
    chk("R10", "latch at compare", {31'b0, flagLatchN}, 32'h0);
    chk("R8", "compare bit", {31'b0, status[5]}, 32'h1);
    cyc();
    chk("R10", "pulse released", {31'b0, flagPulseN}, 32'h1);
    chk("R10", "latch held", {31'b0, flagLatchN}, 32'h0);
    clrSt = 1; cyc();
    chk("R10", "latch released by clear", {31'b0, flagLatchN}, 32'h1);
    setM1(8'h03);
    clrCnt = 1; cyc();
    stepD(1);
    chk("R10", "masked borrow keeps latch high", {31'b0, flagLatchN}, 32'h1);
    clrSt = 1; cyc();

    curReq = "R5";
    setM0(8'h08);
    setPre(32'h3);
    clrCnt = 1; cyc();
    stepU(5);
    chk("R5", "hold at preset", countVal, 32'h3);
    chk("R5", "carry at top", {31'b0, status[7]}, 32'h1);
    stepD(1);
    chk("R5", "reverse from top", countVal, 32'h2);
    stepD(3);
    chk("R5", "hold at zero", countVal, 32'h0);
    chk("R5", "borrow at zero", {31'b0, status[6]}, 32'h1);
    clrSt = 1; cyc();

    curReq = "R6";
    setM0(8'h0C);
    stepU(4);
    chk("R6", "wrap up to zero", countVal, 32'h0);
    chk("R6", "carry on wrap", {31'b0, status[7]}, 32'h1);
    stepD(1);
    chk("R6", "wrap down to preset", countVal, 32'h3);
    chk("R6", "borrow on wrap", {31'b0, status[6]}, 32'h1);

    curReq = "R4";
    setM0(8'h04);
    setPre(32'hFE);
    ldCnt = 1; cyc();
    stepU(2);
    stepU(2);
    chk("R4", "halted after carry", countVal, 32'h0);
    ldCnt = 1; cyc();
    chk("R12", "load from preset", countVal, 32'hFE);
    stepU(1);
    chk("R4", "resumes after load", countVal, 32'hFF);

    curReq = "R7";
    setPre(32'h22);
    setM0(8'h10);
    idx = 1; cUp = 1; cyc();
    chk("R7", "index load beats step", countVal, 32'h22);
    setM0(8'h20);
    idx = 1; cUp = 1; cyc();
    chk("R7", "index clear beats step", countVal, 32'h0);
    setM0(8'h30);
    stepU(2);
    idx = 1; cUp = 1; cyc();
    chk("R7", "snapshot pre-step", snapVal, 32'h2);
    chk("R7", "count advances with snapshot", countVal, 32'h3);
    setM0(8'h00);
    clrSt = 1; cyc();
    idx = 1; cyc();
    chk("R7", "no action keeps count", countVal, 32'h3);
    chk("R7", "index bit set", {31'b0, status[4]}, 32'h1);
    stepU(1);
    ldSnp = 1; cyc();
    chk("R12", "snapshot strobe", snapVal, 32'h4);

    curReq = "R11";
    enPin = 0;
    stepU(1);
    chk("R11", "pin low blocks count", countVal, 32'h4);
    chk("R11", "enable bit low", {31'b0, status[3]}, 32'h0);
    enPin = 1;
    setM1(8'h07);
    stepU(1);
    chk("R11", "disable bit blocks count", countVal, 32'h4);
    setM1(8'h03);
    cUp = 1; cDn = 1; cyc();
    chk("R11", "both pulses ignored", countVal, 32'h4);
    stepU(1);
    chk("R11", "counts when enabled", countVal, 32'h5);

    curReq = "R8";
    setPre(32'h80);
    ldCnt = 1; cyc();
    chk("R8", "sign at 1B", {31'b0, status[0]}, 32'h1);
    stepD(1);
    chk("R8", "direction down", {30'b0, status[1:0]}, 32'h0);

    curReq = "R12";
    clrM0 = 1; wrM0 = 1; data = 32'hFF; cyc();
    chk("R12", "mode clear beats write", {24'b0, mode0Val}, 32'h0);
    clrCnt = 1; cyc();
    chk("R12", "counter clear", countVal, 32'h0);

    curReq = "R8";
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      enPin = r[28] | r[29];
      cUp = r[0]; cDn = r[1] & r[2];
      idx = (r[7:4] == 0);
      clrCnt = (r[11:8] == 0);
      ldCnt = (r[15:12] == 1);
      ldSnp = (r[15:12] == 2);
      clrSt = (r[19:16] == 0);
      case (r[27:24])
        4'd0: begin wrPre = 1; data = $urandom % 6; end
        4'd1: begin wrM0 = 1; data = $urandom; end
        4'd2: begin wrM1 = 1; data = $urandom | 32'h1; end
        default: ;
      endcase
      cyc();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule